// File: doc/BRIEF.md
# SPI Radio Command Engine

This block lets a local host issue commands to a radio transceiver attached over SPI. The transceiver shows it is ready by answering a read-buffer opcode with an all-ones byte. The host first loads up to `PAYLOAD_DEPTH` payload bytes through a byte-wide write port. It then raises a request that carries an opcode, a payload length and an optional response length.

The engine polls the device for readiness and then sends the opcode and payload in one chip-select frame. If a response was asked for, it polls again. Once the device reports ready, chip select stays low and the requested response bytes are clocked in within the same frame. Each response byte is handed to the host with a one-cycle valid strobe.

The request ends with a one-cycle `done_o` pulse, or with a `timeout_o` pulse if the device never becomes ready. Clock division, chip-select setup and hold, the inter-frame gaps and the poll limit are all parameters counted in system clocks.

Top module: `spi_radio_cmd`

## Requirements
- R1: A readiness poll is one chip-select frame of exactly two bytes: the engine sends 0x44, then sends 0x00 while capturing the device's reply.
- R2: Only a reply of 0xFF counts as ready. Any other reply (0xFE and 0x00 included) causes another poll, and the command frame is not sent.
- R3: After `MAX_POLLS` consecutive non-ready replies the engine pulses `timeout_o`, sends no command frame, drives chip select high and clears the payload buffer.
- R4: After a successful poll, the opcode is sent first and then `req_len_i` buffer bytes in write order, all in one chip-select frame. Chip select is low only while a request is in progress.
- R5: With `req_resp_len_i` = N > 0, a second poll sequence follows the command frame. After its 0xFF reply, chip select stays low and N more bytes are read. Each is presented on `resp_data_o` with `resp_valid_o` high for one cycle, in arrival order, while chip select is still low.
- R6: When a response poll gets a non-ready reply, chip select goes high and stays high for at least `RESP_GAP` cycles before the next poll.
- R7: The payload buffer takes one byte per cycle on which `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is low while the buffer holds `PAYLOAD_DEPTH` bytes or a request is in progress. The buffer is empty again after `done_o` or `timeout_o`.
- R8: `busy_o` rises the cycle after a request is accepted in the idle state. It falls in the same cycle that `done_o` or `timeout_o` pulses. A `req_valid_i` raised while busy is ignored.
- R9: The SPI lines follow mode 0. SCLK is low whenever chip select is high, MOSI does not change while SCLK is high, and data is most significant bit first.
- R10: Each accepted request ends with exactly one pulse of either `done_o` or `timeout_o`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Payload byte valid |
| wr_data_i | input | 8 | Payload byte |
| wr_ready_o | output | 1 | Payload buffer can take a byte |
| req_valid_i | input | 1 | Start a command (sampled when idle) |
| req_opcode_i | input | 8 | Command opcode |
| req_len_i | input | $clog2(PAYLOAD_DEPTH+1) | Payload bytes to send |
| req_resp_len_i | input | $clog2(RESP_MAX+1) | Response bytes to read, 0 for none |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle poll timeout pulse |
| resp_valid_o | output | 1 | Response byte strobe |
| resp_data_o | output | 8 | Response byte |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | Master data out |
| spi_miso_i | input | 1 | Master data in |

## Verification
A sequencer that takes the wrong phase shows up on the wire within one byte time. Examples are a poll frame with a third byte, a command frame that starts before a 0xFF, or a response read that raises chip select after the status byte. The SPI slave model in the bench decodes every frame, so each of these is caught at the frame in which it happens. A poll counter that is off by one changes the number of poll frames before `timeout_o`, and that count is compared exactly. A payload pointer that is stale or never cleared corrupts the bytes of the next command frame, or leaves `wr_ready_o` low after completion. Both are visible on the first request that follows.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_NEXT,
    S_XFER,
    S_HOLD,
    S_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    P_CTS,
    P_CMD,
    P_RPOLL,
    P_RDATA
  } seq_phase_e;

  typedef enum logic [1:0] {
    F_NONE,
    F_DONE,
    F_TMO
  } seq_fin_e;

  localparam logic [7:0] POLL_OPCODE = 8'h44;
  localparam logic [7:0] READY_BYTE  = 8'hFF;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_mode0_shifter.sv
module spi_mode0_shifter #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  localparam int DIV_W = $clog2(CLK_HALF + 1);

  logic             active_q;
  logic             sclk_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sr_q;
  logic [7:0]       rx_sr_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_sr_q  <= '0;
      rx_sr_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        tx_sr_q  <= tx_i;
        bit_q    <= '0;
        div_q    <= DIV_W'(CLK_HALF - 1);
      end else if (active_q) begin
        if (div_q == '0) begin
          div_q <= DIV_W'(CLK_HALF - 1);
          if (!sclk_q) begin
            sclk_q  <= 1'b1;
            rx_sr_q <= {rx_sr_q[6:0], miso_i};
          end else begin
            sclk_q  <= 1'b0;
            tx_sr_q <= {tx_sr_q[6:0], 1'b0};
            bit_q   <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q - DIV_W'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_sr_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_sr_q[7];

  // R9
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));

  // R9
  sclk_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);

endmodule

// File: rtl/payload_buf.sv
module payload_buf #(
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lock_i,
  input  logic                     clear_i,
  input  logic                     wr_valid_i,
  input  logic [7:0]               wr_data_i,
  output logic                     wr_ready_o,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic [7:0]               rd_data_o
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en;

  assign wr_ready_o = !lock_i && (cnt_q < CNT_W'(DEPTH));
  assign wr_en      = wr_valid_i && wr_ready_o && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (wr_en)   cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[cnt_q[ADDR_W-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];

  // R7
  refused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o && !clear_i) |=> $stable(cnt_q));

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_radio_cmd.sv
module spi_radio_cmd
  import spi_cmd_pkg::*;
#(
  parameter int CLK_HALF      = 2,
  parameter int CS_SETUP      = 2,
  parameter int CS_HOLD       = 2,
  parameter int FRAME_GAP     = 4,
  parameter int RESP_GAP      = 2500,
  parameter int MAX_POLLS     = 65535,
  parameter int PAYLOAD_DEPTH = 16,
  parameter int RESP_MAX      = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_valid_i,
  input  logic [7:0]                         wr_data_i,
  output logic                               wr_ready_o,
  input  logic                               req_valid_i,
  input  logic [7:0]                         req_opcode_i,
  input  logic [$clog2(PAYLOAD_DEPTH+1)-1:0] req_len_i,
  input  logic [$clog2(RESP_MAX+1)-1:0]      req_resp_len_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic                               timeout_o,
  output logic                               resp_valid_o,
  output logic [7:0]                         resp_data_o,
  output logic                               spi_cs_no,
  output logic                               spi_sclk_o,
  output logic                               spi_mosi_o,
  input  logic                               spi_miso_i
);

  localparam int LEN_W   = $clog2(PAYLOAD_DEPTH + 1);
  localparam int RLEN_W  = $clog2(RESP_MAX + 1);
  localparam int IDX_W   = max2(LEN_W, RLEN_W);
  localparam int ADDR_W  = $clog2(PAYLOAD_DEPTH);
  localparam int POLL_W  = $clog2(MAX_POLLS + 1);
  localparam int TMR_MAX = max2(max2(CS_SETUP, CS_HOLD), max2(FRAME_GAP, RESP_GAP));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e        state_q;
  seq_phase_e        phase_q;
  seq_fin_e          fin_q;
  logic              cs_n_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [POLL_W-1:0] polls_q;
  logic [7:0]        opcode_q;
  logic [IDX_W-1:0]  len_q;
  logic [IDX_W-1:0]  rlen_q;
  logic              done_q, tmo_q, rvalid_q;
  logic [7:0]        rdata_q;

  logic              sh_start, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  logic              buf_clear;
  logic [7:0]        buf_rd;
  logic [IDX_W-1:0]  idx_m1;
  logic              last_poll;

  assign busy_o    = (state_q != S_IDLE);
  assign sh_start  = (state_q == S_NEXT);
  assign buf_clear = (state_q == S_HOLD) && (tmr_q == '0) && (fin_q != F_NONE);
  assign idx_m1    = idx_q - IDX_W'(1);
  assign last_poll = (polls_q == POLL_W'(MAX_POLLS - 1));

  always_comb begin
    case (phase_q)
      P_CTS, P_RPOLL: sh_tx = (idx_q == '0) ? POLL_OPCODE : 8'h00;
      P_CMD:          sh_tx = (idx_q == '0) ? opcode_q : buf_rd;
      default:        sh_tx = 8'h00;
    endcase
  end

  payload_buf #(
    .DEPTH(PAYLOAD_DEPTH)
  ) i_payload_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (busy_o),
    .clear_i    (buf_clear),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_ready_o (wr_ready_o),
    .rd_idx_i   (idx_m1[ADDR_W-1:0]),
    .rd_data_o  (buf_rd)
  );

  spi_mode0_shifter #(
    .CLK_HALF(CLK_HALF)
  ) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .miso_i  (spi_miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      phase_q  <= P_CTS;
      fin_q    <= F_NONE;
      cs_n_q   <= 1'b1;
      tmr_q    <= '0;
      idx_q    <= '0;
      polls_q  <= '0;
      opcode_q <= '0;
      len_q    <= '0;
      rlen_q   <= '0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
      rvalid_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            opcode_q <= req_opcode_i;
            len_q    <= (req_len_i > LEN_W'(PAYLOAD_DEPTH)) ?
                        IDX_W'(PAYLOAD_DEPTH) : IDX_W'(req_len_i);
            rlen_q   <= (req_resp_len_i > RLEN_W'(RESP_MAX)) ?
                        IDX_W'(RESP_MAX) : IDX_W'(req_resp_len_i);
            phase_q  <= P_CTS;
            fin_q    <= F_NONE;
            polls_q  <= '0;
            idx_q    <= '0;
            cs_n_q   <= 1'b0;
            tmr_q    <= TMR_W'(CS_SETUP);
            state_q  <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (tmr_q == '0) state_q <= S_NEXT;
          else             tmr_q   <= tmr_q - TMR_W'(1);
        end
        S_NEXT: state_q <= S_XFER;
        S_XFER: begin
          if (sh_done) begin
            case (phase_q)
              P_CTS, P_RPOLL: begin
                if (idx_q == '0) begin
                  idx_q   <= IDX_W'(1);
                  state_q <= S_NEXT;
                end else if (sh_rx == READY_BYTE) begin
                  idx_q <= '0;
                  if (phase_q == P_CTS) begin
                    phase_q <= P_CMD;
                    tmr_q   <= TMR_W'(CS_HOLD);
                    state_q <= S_HOLD;
                  end else begin
                    // stay selected, data follows in this frame
                    phase_q <= P_RDATA;
                    state_q <= S_NEXT;
                  end
                end else begin
                  idx_q   <= '0;
                  polls_q <= polls_q + POLL_W'(1);
                  if (last_poll) fin_q <= F_TMO;
                  tmr_q   <= TMR_W'(CS_HOLD);
                  state_q <= S_HOLD;
                end
              end
              P_CMD: begin
                if (idx_q == len_q) begin
                  fin_q   <= (rlen_q == '0) ? F_DONE : F_NONE;
                  phase_q <= P_RPOLL;
                  polls_q <= '0;
                  idx_q   <= '0;
                  tmr_q   <= TMR_W'(CS_HOLD);
                  state_q <= S_HOLD;
                end else begin
                  idx_q   <= idx_q + IDX_W'(1);
                  state_q <= S_NEXT;
                end
              end
              default: begin
                rvalid_q <= 1'b1;
                rdata_q  <= sh_rx;
                if (idx_q == rlen_q - IDX_W'(1)) begin
                  fin_q   <= F_DONE;
                  tmr_q   <= TMR_W'(CS_HOLD);
                  state_q <= S_HOLD;
                end else begin
                  idx_q   <= idx_q + IDX_W'(1);
                  state_q <= S_NEXT;
                end
              end
            endcase
          end
        end
        S_HOLD: begin
          if (tmr_q == '0) begin
            cs_n_q <= 1'b1;
            case (fin_q)
              F_DONE: begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
              F_TMO: begin
                tmo_q   <= 1'b1;
                state_q <= S_IDLE;
              end
              default: begin
                tmr_q   <= (phase_q == P_RPOLL && polls_q != '0) ?
                           TMR_W'(RESP_GAP) : TMR_W'(FRAME_GAP);
                state_q <= S_GAP;
              end
            endcase
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        S_GAP: begin
          if (tmr_q == '0) begin
            cs_n_q  <= 1'b0;
            tmr_q   <= TMR_W'(CS_SETUP);
            state_q <= S_SETUP;
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o       = done_q;
  assign timeout_o    = tmo_q;
  assign resp_valid_o = rvalid_q;
  assign resp_data_o  = rdata_q;
  assign spi_cs_no    = cs_n_q;

  // R9
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  // R10
  end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o));

  // R3
  tmo_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> spi_cs_no);

  // R5
  resp_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !spi_cs_no);

  // R4
  cs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy_o);

endmodule

// File: tb/test_spi_radio_cmd.sv
`timescale 1ns/1ps
module test_spi_radio_cmd;

  localparam int DEPTH     = 16;
  localparam int RESP_GAP  = 20;
  localparam int MAX_POLLS = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       req_valid = 1'b0;
  logic [7:0] req_opcode = '0;
  logic [4:0] req_len = '0;
  logic [4:0] req_rlen = '0;
  logic       busy, done, tmo, rvalid;
  logic [7:0] rdata;
  logic       cs_n, sclk, mosi;
  logic       miso = 1'b0;

  always #2 clk = ~clk;

  spi_radio_cmd #(
    .CLK_HALF(2), .CS_SETUP(2), .CS_HOLD(2), .FRAME_GAP(3),
    .RESP_GAP(RESP_GAP), .MAX_POLLS(MAX_POLLS),
    .PAYLOAD_DEPTH(DEPTH), .RESP_MAX(16)
  ) i_spi_radio_cmd (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .req_valid_i(req_valid), .req_opcode_i(req_opcode),
    .req_len_i(req_len), .req_resp_len_i(req_rlen),
    .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .resp_valid_o(rvalid), .resp_data_o(rdata),
    .spi_cs_no(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_bytes[$];
  logic [7:0] exp_resp[$];

  // slave model state
  logic [7:0] s_rx = '0, s_out = '0, s_op = '0;
  int  s_bit = 0, s_byte = 0, s_ridx = 0;
  bit  s_phase2 = 0, last_fail = 0, never_ready = 0;
  int  cts_busy = 0, resp_busy = 0;
  int  polls1 = 0, polls2 = 0, cmd_frames = 0, done_cnt = 0, tmo_cnt = 0;
  int  hi_cnt = 0;
  bit  sclk_bad = 0, mosi_bad = 0;
  logic [7:0] resp_mem [16];
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always @(posedge clk) begin
    if (cs_n) hi_cnt++;
    else      hi_cnt = 0;
  end

  always @(negedge cs_n) begin
    s_bit = 0; s_byte = 0; s_ridx = 0; s_out = '0; miso = 1'b0;
    if (s_phase2 && last_fail)
      chk(hi_cnt >= RESP_GAP, "R6 response retry gap", hi_cnt, RESP_GAP);
  end

  always @(posedge cs_n) begin
    if (s_byte > 0 && s_op != 8'h44) s_phase2 = 1;
    if (s_byte > 0 && s_op == 8'h44)
      chk(s_byte == 2 || (s_phase2 && !last_fail), "R1 poll frame length", s_byte, 2);
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      s_rx = {s_rx[6:0], mosi};
      s_bit++;
      if (s_bit == 8) begin
        s_bit = 0;
        if (s_byte == 0) begin
          s_op = s_rx;
          if (s_rx == 8'h44) begin
            bit rdy;
            if (s_phase2) polls2++; else polls1++;
            rdy = !never_ready && (s_phase2 ? (resp_busy == 0) : (cts_busy == 0));
            if (!rdy) begin
              if (s_phase2 && resp_busy > 0) resp_busy--;
              if (!s_phase2 && cts_busy > 0) cts_busy--;
            end
            last_fail = !rdy;
            s_out = rdy ? 8'hFF : (s_phase2 ? 8'h00 : 8'hFE);
          end else begin
            cmd_frames++;
            last_fail = 0;
            if (exp_bytes.size() == 0) chk(0, "R4 unexpected opcode", s_rx, 0);
            else begin
              logic [7:0] e;
              e = exp_bytes.pop_front();
              chk(s_rx == e, "R4 opcode byte", s_rx, e);
            end
            s_out = '0;
          end
        end else if (s_op == 8'h44) begin
          if (s_byte == 1) chk(s_rx == 8'h00, "R1 poll read byte", s_rx, 0);
          s_out = resp_mem[s_ridx[3:0]];
          s_ridx++;
        end else begin
          if (exp_bytes.size() == 0) chk(0, "R4 extra payload byte", s_rx, 0);
          else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            chk(s_rx == e, "R4 payload byte", s_rx, e);
          end
          s_out = '0;
        end
        s_byte++;
        miso = s_out[7];
      end
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && s_bit != 0) begin
      s_out = {s_out[6:0], 1'b0};
      miso  = s_out[7];
    end
  end

  // response monitor and line-discipline watcher
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) sclk_bad = 1;
      if (sclk && prev_sclk && mosi != prev_mosi) mosi_bad = 1;
      if (done) done_cnt++;
      if (tmo) tmo_cnt++;
      if (done && tmo) chk(0, "R10 done with timeout", 1, 0);
      if (rvalid) begin
        chk(!cs_n, "R5 response inside frame", cs_n, 0);
        if (exp_resp.size() == 0) chk(0, "R5 unexpected response", rdata, 0);
        else begin
          logic [7:0] e;
          e = exp_resp.pop_front();
          chk(rdata == e, "R5 response byte", rdata, e);
        end
      end
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int n, input int rl,
                         input int cb, input int rb, input bit never,
                         input bit stray, input int exp_polls1, input int exp_polls2);
    int frames0, done0, tmo0, wait_cyc;
    s_phase2 = 0; last_fail = 0;
    polls1 = 0; polls2 = 0;
    cts_busy = cb; resp_busy = rb; never_ready = never;
    frames0 = cmd_frames; done0 = done_cnt; tmo0 = tmo_cnt;
    if (!never) exp_bytes.push_back(op);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'(op + 8'(i * 7) + 8'h10);
      wr_byte(b);
      if (!never) exp_bytes.push_back(b);
    end
    for (int i = 0; i < 16; i++) resp_mem[i] = 8'(op ^ 8'(i * 53));
    resp_mem[0] = 8'hFF;
    if (!never) for (int i = 0; i < rl; i++) exp_resp.push_back(resp_mem[i]);
    @(negedge clk);
    req_valid = 1'b1; req_opcode = op; req_len = 5'(n); req_rlen = 5'(rl);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R8 busy after accept", busy, 1);
    chk(!wr_ready, "R7 ready low while busy", wr_ready, 0);
    if (stray) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_opcode = 8'h99; req_len = 5'd0; req_rlen = 5'd0;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_cyc = 0;
    while (!done && !tmo && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk(wait_cyc < 20000, "R10 request completes", wait_cyc, 0);
    chk(!busy, "R8 busy drops with end pulse", busy, 0);
    chk(cs_n, "R3 cs high at end", cs_n, 1);
    if (never) begin
      chk(tmo, "R3 timeout pulse", tmo, 1);
      chk(polls1 == exp_polls1, "R3 polls before timeout", polls1, exp_polls1);
      chk(cmd_frames == frames0, "R3 no command frame", cmd_frames - frames0, 0);
    end else begin
      chk(done, "R10 done pulse", done, 1);
      chk(polls1 == exp_polls1, "R2 polls before command", polls1, exp_polls1);
      chk(polls2 == exp_polls2, "R5 polls before response", polls2, exp_polls2);
      chk(exp_bytes.size() == 0, "R4 all bytes sent", exp_bytes.size(), 0);
      chk(exp_resp.size() == 0, "R5 all responses seen", exp_resp.size(), 0);
    end
    repeat (300) @(negedge clk);
    chk(cmd_frames - frames0 == (never ? 0 : 1), "R8 one command frame", cmd_frames - frames0, never ? 0 : 1);
    chk((done_cnt - done0) + (tmo_cnt - tmo0) == 1, "R10 single end pulse",
        (done_cnt - done0) + (tmo_cnt - tmo0), 1);
    chk(wr_ready, "R7 buffer free after end", wr_ready, 1);
    exp_bytes.delete();
    exp_resp.delete();
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n, "R9 reset cs", cs_n, 1);
    chk(!sclk, "R9 reset sclk", sclk, 0);
    chk(!busy && !done && !tmo, "R8 reset idle", {busy, done, tmo}, 0);
    chk(wr_ready, "R7 reset ready", wr_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R4: ready at once, short payload
    run_cmd(8'h11, 2, 0, 0, 0, 0, 0, 1, 0);
    // R2: three non-ready replies (0xFE) before 0xFF
    run_cmd(8'h13, 3, 0, 3, 0, 0, 0, 4, 0);
    // R5 R6: response with retries
    run_cmd(8'h01, 0, 4, 1, 2, 0, 0, 2, 3);
    // R7: full buffer, refused extra write
    begin
      int frames0;
      frames0 = cmd_frames;
      s_phase2 = 0; last_fail = 0; polls1 = 0; polls2 = 0;
      cts_busy = 0; resp_busy = 0; never_ready = 0;
      exp_bytes.push_back(8'h20);
      for (int i = 0; i < DEPTH; i++) begin
        wr_byte(8'(8'h80 + i));
        exp_bytes.push_back(8'(8'h80 + i));
      end
      @(negedge clk);
      chk(!wr_ready, "R7 ready low when full", wr_ready, 0);
      wr_valid = 1'b1; wr_data = 8'h5A;
      @(negedge clk);
      wr_valid = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_opcode = 8'h20; req_len = 5'(DEPTH); req_rlen = 5'd0;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done && !tmo) @(negedge clk);
      chk(done, "R7 full command done", done, 1);
      chk(exp_bytes.size() == 0, "R7 sixteen bytes sent", exp_bytes.size(), 0);
      repeat (20) @(negedge clk);
      chk(cmd_frames - frames0 == 1, "R7 one frame", cmd_frames - frames0, 1);
      chk(wr_ready, "R7 cleared after done", wr_ready, 1);
    end
    // R3: never ready
    run_cmd(8'h31, 1, 0, 0, 0, 1, 0, MAX_POLLS, 0);
    // R8: stray request while busy
    run_cmd(8'h34, 1, 0, 2, 0, 0, 1, 3, 0);
    // R5: single response byte, device ready at once
    run_cmd(8'h14, 2, 1, 0, 0, 0, 0, 1, 1);

    chk(!sclk_bad, "R9 sclk low while deselected", sclk_bad, 0);
    chk(!mosi_bad, "R9 mosi steady while sclk high", mosi_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule